// File: doc/BRIEF.md
# UART Interrupt Status and Clear Unit

This unit keeps the interrupt state of a UART register interface. It watches the fill levels of the transmit and receive FIFOs against programmable trigger thresholds, the last-bit-sent strobe from the transmit shifter, push and pop strobes on the FIFOs, and three asynchronous modem lines: data-set-ready, data-carrier-detect and clear-to-send. It holds one sticky raw flag per source, presents the flags gated by a mask register, and drives a single combined interrupt line.

Software clears flags with write-one-to-clear writes from a simple register bus. The transmit and receive flags also clear themselves when the FIFO fill moves back across the trigger. When the FIFOs are switched off, they clear instead on a single byte written to the transmit side or read from the receive side. The transmit flag has two selectable sources: a crossing of the FIFO threshold, or the end of the last data bit of a character. The FIFOs, shifters and baud logic are outside this unit, and it sees them only through counts and strobes.

Top module: `uart_irq_status`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every raw flag, every masked flag and the interrupt line are 0.
- R2: Status vectors use bit 5 = transmit, bit 4 = receive, bit 3 = data-set-ready, bit 2 = data-carrier-detect, bit 1 = clear-to-send. A masked bit is 1 exactly when its raw flag is 1 and the same bit of the mask input is 1.
- R3: With the end-of-transmission mode off, the transmit flag sets in the cycle after the transmit "at or below trigger" condition becomes true. With the FIFO on, that condition is level <= trigger. With the FIFO off, it is level == 0.
- R4: With the end-of-transmission mode on, the transmit flag sets in the cycle after a last-bit strobe, and threshold crossings do not set it.
- R5: The transmit flag clears in the cycle after one of these: a clear write with data bit 5 set; with the FIFO on, the "at or below trigger" condition becoming false; with the FIFO off, a push strobe.
- R6: The receive flag sets in the cycle after the receive "at or above trigger" condition becomes true. With the FIFO on, that condition is level >= trigger. With the FIFO off, it is level != 0.
- R7: The receive flag clears in the cycle after one of these: a clear write with data bit 4 set; with the FIFO on, that condition becoming false; with the FIFO off, a pop strobe.
- R8: A change on a modem input (input bit 2 = data-set-ready, 1 = data-carrier-detect, 0 = clear-to-send) sets its flag three clock edges later, through a two-stage synchronizer and an edge compare. Modem flags clear only on a clear write with their bit set.
- R9: When a set event and a clear for the same flag fall in the same cycle, the flag ends up set.
- R10: The interrupt line equals the OR of the masked flags, one cycle late.
- R11: With the modem parameter off, raw and masked bits 3 to 1 always read 0, and modem changes and clear writes leave them 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFOs enabled |
| eot_mode | input | 1 | Transmit flag taken from the last-bit strobe |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| tx_trig | input | LVL_W | Transmit trigger level |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_trig | input | LVL_W | Receive trigger level |
| tx_push | input | 1 | A byte was written to the transmit side |
| rx_pop | input | 1 | A byte was read from the receive side |
| tx_last | input | 1 | Last data bit of a character was sent |
| modem_in | input | 3 | Asynchronous modem lines {dsr, dcd, cts} |
| mask | input | 5 | Interrupt enables, bits 5..1 |
| clr_wr | input | 1 | Write strobe for the clear register |
| clr_data | input | 5 | Write-one-to-clear data, bits 5..1 |
| irq_raw | output | 5 | Raw flags, bits 5..1 |
| irq_masked | output | 5 | Masked flags, bits 5..1 |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the moment a FIFO level lands exactly on the trigger. A design with an off-by-one compare would set a cycle early or never set at all. It targets a clear write that collides with a set event, where a design giving the clear priority would lose an interrupt. It switches the FIFOs off so that only a push or pop, not a level move, clears the flag, and a design that mixed the two would clear too early or never. It also counts the modem synchronizer latency, checks that end-of-transmission mode ignores crossings, and checks a build without modem support, where a stray modem flag would show on bits 3 to 1.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int STAT_HI = 5;
    localparam int STAT_LO = 1;
    localparam int BIT_TX  = 5;
    localparam int BIT_RX  = 4;
    localparam int BIT_DSR = 3;
    localparam int BIT_DCD = 2;
    localparam int BIT_CTS = 1;
    localparam int MDM_W   = 3;

    typedef logic [STAT_HI:STAT_LO] stat_vec_t;

    // Transitions of a level-versus-trigger relationship
    typedef struct packed {
        logic enter;
        logic leave;
    } cross_ev_t;

    // Sticky update: a set in the same cycle beats a clear
    function automatic stat_vec_t sticky_next(stat_vec_t cur, stat_vec_t set_v, stat_vec_t clr_v);
        return set_v | (cur & ~clr_v);
    endfunction

endpackage

// File: rtl/uart_irq_cross.sv
module uart_irq_cross #(
    parameter int LVL_W = 5,
    parameter bit ABOVE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    output uart_irq_pkg::cross_ev_t ev
);
    // An empty FIFO is at/below the transmit trigger and below the receive one
    localparam logic PREV_RST = ~ABOVE;

    logic cond;
    logic prev_q;

    generate
        if (ABOVE) begin : g_above
            always_comb cond = fifo_en ? (level >= trig) : (level != '0);
        end else begin : g_below
            always_comb cond = fifo_en ? (level <= trig) : (level == '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PREV_RST;
        else     prev_q <= cond;
    end

    always_comb begin
        ev.enter = cond & ~prev_q;
        ev.leave = ~cond & prev_q;
    end
endmodule

// File: rtl/uart_irq_msync.sv
module uart_irq_msync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] change
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= async_in[i];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign change[i] = s2_q ^ s3_q;
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int LVL_W    = 5,
    parameter bit MODEM_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             eot_mode,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             tx_push,
    input  logic             rx_pop,
    input  logic             tx_last,
    input  logic [2:0]       modem_in,
    input  logic [5:1]       mask,
    input  logic             clr_wr,
    input  logic [5:1]       clr_data,
    output logic [5:1]       irq_raw,
    output logic [5:1]       irq_masked,
    output logic             irq_o
);
    cross_ev_t       tx_ev, rx_ev;
    logic [MDM_W-1:0] mdm_chg;
    stat_vec_t       set_v, clr_v, raw_q;
    logic            irq_q;

    uart_irq_cross #(.LVL_W(LVL_W), .ABOVE(1'b0)) i_tx_cross (
        .clk(clk), .rst(rst), .fifo_en(fifo_en),
        .level(tx_level), .trig(tx_trig), .ev(tx_ev)
    );

    uart_irq_cross #(.LVL_W(LVL_W), .ABOVE(1'b1)) i_rx_cross (
        .clk(clk), .rst(rst), .fifo_en(fifo_en),
        .level(rx_level), .trig(rx_trig), .ev(rx_ev)
    );

    generate
        if (MODEM_EN) begin : g_modem
            uart_irq_msync #(.N(MDM_W)) i_msync (
                .clk(clk), .rst(rst), .async_in(modem_in), .change(mdm_chg)
            );
        end else begin : g_no_modem
            assign mdm_chg = '0;
        end
    endgenerate

    always_comb begin
        set_v = '0;
        clr_v = clr_wr ? clr_data : '0;
        // transmit: source chosen by mode, self-clear chosen by FIFO enable
        set_v[BIT_TX] = eot_mode ? tx_last : tx_ev.enter;
        if (fifo_en ? tx_ev.leave : tx_push) clr_v[BIT_TX] = 1'b1;
        // receive
        set_v[BIT_RX] = rx_ev.enter;
        if (fifo_en ? rx_ev.leave : rx_pop) clr_v[BIT_RX] = 1'b1;
        // modem lines
        set_v[BIT_DSR] = mdm_chg[2];
        set_v[BIT_DCD] = mdm_chg[1];
        set_v[BIT_CTS] = mdm_chg[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            irq_q <= 1'b0;
        end else begin
            raw_q <= sticky_next(raw_q, set_v, clr_v);
            irq_q <= |irq_masked;
        end
    end

    assign irq_raw    = raw_q;
    assign irq_masked = raw_q & mask;
    assign irq_o      = irq_q;
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
    parameter bit MODEM_EN = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       eot_mode,
    input logic       tx_last,
    input logic       clr_wr,
    input logic [5:1] clr_data,
    input logic [5:1] irq_raw,
    input logic [5:1] irq_masked,
    input logic       irq_o
);
    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (irq_raw == '0 && irq_o == 1'b0));

    // R10
    p_irq_lag_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_o == $past(|irq_masked)));

    // R8
    p_modem_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_raw[3]) |-> $past(clr_wr && clr_data[3]));

    // R4
    p_eot_set_r4: assert property (@(posedge clk) disable iff (rst)
        (eot_mode && tx_last) |=> irq_raw[5]);

    // R5
    p_tx_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_data[5] && eot_mode && !tx_last) |=> !irq_raw[5]);

    generate
        if (!MODEM_EN) begin : g_nomdm
            // R11
            p_no_modem_r11: assert property (@(posedge clk) disable iff (rst)
                (irq_raw[3:1] == 3'b000 && irq_masked[3:1] == 3'b000));
        end
    endgenerate
endmodule

bind uart_irq_status uart_irq_status_chk #(.MODEM_EN(MODEM_EN)) i_chk (
    .clk(clk), .rst(rst), .eot_mode(eot_mode), .tx_last(tx_last),
    .clr_wr(clr_wr), .clr_data(clr_data), .irq_raw(irq_raw),
    .irq_masked(irq_masked), .irq_o(irq_o)
);

// File: tb/test_uart_irq_status.sv
`timescale 1ns/1ps
module test_uart_irq_status;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fifo_en = 1'b1, eot_mode = 1'b0;
    logic [LW-1:0] tx_level = '0, tx_trig = 5'd4, rx_level = '0, rx_trig = 5'd4;
    logic          tx_push = 1'b0, rx_pop = 1'b0, tx_last = 1'b0;
    logic [2:0]    modem_in = '0;
    logic [5:1]    mask = 5'b11111;
    logic          clr_wr = 1'b0;
    logic [5:1]    clr_data = '0;
    logic [5:1]    raw, mis, raw2, mis2;
    logic          irq, irq2;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench reference state
    logic [5:1] m_raw = '0;
    logic       m_irq = 1'b0, m_txp = 1'b1, m_rxp = 1'b0;
    logic [2:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;

    always #2.5 clk = ~clk;

    uart_irq_status #(.LVL_W(LW), .MODEM_EN(1'b1)) i_uart_irq_status (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .eot_mode(eot_mode),
        .tx_level(tx_level), .tx_trig(tx_trig), .rx_level(rx_level), .rx_trig(rx_trig),
        .tx_push(tx_push), .rx_pop(rx_pop), .tx_last(tx_last), .modem_in(modem_in),
        .mask(mask), .clr_wr(clr_wr), .clr_data(clr_data),
        .irq_raw(raw), .irq_masked(mis), .irq_o(irq)
    );

    uart_irq_status #(.LVL_W(LW), .MODEM_EN(1'b0)) i_nomodem (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .eot_mode(eot_mode),
        .tx_level(tx_level), .tx_trig(tx_trig), .rx_level(rx_level), .rx_trig(rx_trig),
        .tx_push(tx_push), .rx_pop(rx_pop), .tx_last(tx_last), .modem_in(modem_in),
        .mask(mask), .clr_wr(clr_wr), .clr_data(clr_data),
        .irq_raw(raw2), .irq_masked(mis2), .irq_o(irq2)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input int b);
        if (b == 5) return "R5";
        if (b == 4) return "R7";
        return "R8";
    endfunction

    task automatic compare();
        for (int b = 1; b <= 5; b++)
            check(raw[b] === m_raw[b], tag_of(b), 32'(raw[b]), 32'(m_raw[b]));
        check(mis === (m_raw & mask), "R2", 32'(mis), 32'(m_raw & mask));
        check(irq === m_irq, "R10", 32'(irq), 32'(m_irq));
        check(raw2[3:1] === 3'b000 && mis2[3:1] === 3'b000, "R11", 32'(raw2), 32'(m_raw & 5'b11000));
        check(raw2[5:4] === m_raw[5:4], "R11", 32'(raw2[5:4]), 32'(m_raw[5:4]));
    endtask

    // one clock: predict from the inputs, step, compare, release strobes
    task automatic cyc();
        bit tc, rc;
        logic [5:1] s, c, nraw;
        logic nirq;
        tc = fifo_en ? (tx_level <= tx_trig) : (tx_level == '0);
        rc = fifo_en ? (rx_level >= rx_trig) : (rx_level != '0);
        s = '0;
        c = clr_wr ? clr_data : '0;
        s[5] = eot_mode ? tx_last : (tc && !m_txp);
        if (fifo_en ? (!tc && m_txp) : tx_push) c[5] = 1'b1;
        s[4] = rc && !m_rxp;
        if (fifo_en ? (!rc && m_rxp) : rx_pop) c[4] = 1'b1;
        s[3:1] = m_s2 ^ m_s3;
        nraw = s | (m_raw & ~c);
        nirq = |(m_raw & mask);
        @(posedge clk);
        if (rst) begin
            m_raw = '0; m_irq = 1'b0; m_txp = 1'b1; m_rxp = 1'b0;
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
        end else begin
            m_raw = nraw; m_irq = nirq; m_txp = tc; m_rxp = rc;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = modem_in;
        end
        @(negedge clk);
        compare();
        tx_push = 1'b0; rx_pop = 1'b0; tx_last = 1'b0; clr_wr = 1'b0; clr_data = '0;
    endtask

    task automatic clear_bits(input logic [5:1] d);
        clr_wr = 1'b1; clr_data = d;
        cyc();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1207));
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1: reset state
        check(raw === '0 && mis === '0 && irq === 1'b0, "R1", 32'({raw, irq}), 32'h0);

        // R3: FIFO on, level drops onto trigger
        tx_level = 5'd8; cyc();
        check(raw[5] === 1'b0, "R3", 32'(raw[5]), 32'h0);
        tx_level = 5'd4; cyc();
        check(raw[5] === 1'b1, "R3", 32'(raw[5]), 32'h1);
        check(irq === 1'b0, "R10", 32'(irq), 32'h0);
        cyc();
        check(irq === 1'b1, "R10", 32'(irq), 32'h1);
        // R5: refill above trigger clears
        tx_level = 5'd5; cyc();
        check(raw[5] === 1'b0, "R5", 32'(raw[5]), 32'h0);
        // R9: set and clear collide
        tx_level = 5'd4; clr_wr = 1'b1; clr_data = 5'b10000; cyc();
        check(raw[5] === 1'b1, "R9", 32'(raw[5]), 32'h1);
        clear_bits(5'b10000);
        check(raw[5] === 1'b0, "R5", 32'(raw[5]), 32'h0);
        // FIFO off: empty sets, push clears
        fifo_en = 1'b0; tx_level = 5'd1; cyc();
        check(raw[5] === 1'b0, "R5", 32'(raw[5]), 32'h0);
        tx_level = 5'd0; cyc();
        check(raw[5] === 1'b1, "R3", 32'(raw[5]), 32'h1);
        tx_push = 1'b1; tx_level = 5'd1; cyc();
        check(raw[5] === 1'b0, "R5", 32'(raw[5]), 32'h0);
        fifo_en = 1'b1; tx_level = 5'd8; cyc();

        // R4: end-of-transmission mode
        eot_mode = 1'b1; tx_level = 5'd2; cyc();
        check(raw[5] === 1'b0, "R4", 32'(raw[5]), 32'h0);
        tx_last = 1'b1; cyc();
        check(raw[5] === 1'b1, "R4", 32'(raw[5]), 32'h1);
        clear_bits(5'b10000);
        check(raw[5] === 1'b0, "R5", 32'(raw[5]), 32'h0);
        eot_mode = 1'b0;

        // R6 / R7: receive
        rx_level = 5'd3; cyc();
        check(raw[4] === 1'b0, "R6", 32'(raw[4]), 32'h0);
        rx_level = 5'd4; cyc();
        check(raw[4] === 1'b1, "R6", 32'(raw[4]), 32'h1);
        rx_level = 5'd3; cyc();
        check(raw[4] === 1'b0, "R7", 32'(raw[4]), 32'h0);
        rx_level = 5'd4; cyc();
        clear_bits(5'b01000);
        check(raw[4] === 1'b0, "R7", 32'(raw[4]), 32'h0);
        fifo_en = 1'b0; rx_level = 5'd0; cyc();
        rx_level = 5'd1; cyc();
        check(raw[4] === 1'b1, "R6", 32'(raw[4]), 32'h1);
        rx_pop = 1'b1; rx_level = 5'd0; cyc();
        check(raw[4] === 1'b0, "R7", 32'(raw[4]), 32'h0);
        fifo_en = 1'b1; cyc();

        // R8: modem latency and stickiness
        modem_in = 3'b100; cyc(); cyc();
        check(raw[3] === 1'b0, "R8", 32'(raw[3]), 32'h0);
        cyc();
        check(raw[3] === 1'b1, "R8", 32'(raw[3]), 32'h1);
        repeat (4) cyc();
        check(raw[3] === 1'b1, "R8", 32'(raw[3]), 32'h1);
        clear_bits(5'b00100);
        check(raw[3] === 1'b0, "R8", 32'(raw[3]), 32'h0);
        // R2: mask gating
        modem_in = 3'b101; repeat (3) cyc();
        mask = 5'b11110; cyc();
        check(raw[1] === 1'b1 && mis[1] === 1'b0, "R2", 32'(mis), 32'h0);
        // R11: no-modem build ignores changes and writes
        clear_bits(5'b00111);
        check(raw2[3:1] === 3'b000, "R11", 32'(raw2), 32'h0);
        mask = 5'b11111;

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(3) == 0)
                tx_level = ($urandom_range(1) == 0) ? ((tx_level == 0) ? 5'd0 : tx_level - 1'b1)
                                                    : ((tx_level == 5'd16) ? 5'd16 : tx_level + 1'b1);
            if ($urandom_range(3) == 0)
                rx_level = ($urandom_range(1) == 0) ? ((rx_level == 0) ? 5'd0 : rx_level - 1'b1)
                                                    : ((rx_level == 5'd16) ? 5'd16 : rx_level + 1'b1);
            tx_push = ($urandom_range(7) == 0);
            rx_pop  = ($urandom_range(7) == 0);
            tx_last = ($urandom_range(7) == 0);
            if ($urandom_range(9) == 0) begin
                clr_wr = 1'b1; clr_data = 5'($urandom_range(31));
            end
            if ($urandom_range(199) == 0) fifo_en  = ~fifo_en;
            if ($urandom_range(199) == 0) eot_mode = ~eot_mode;
            if ($urandom_range(299) == 0) tx_trig  = 5'($urandom_range(8, 1));
            if ($urandom_range(299) == 0) rx_trig  = 5'($urandom_range(8, 1));
            if ($urandom_range(49) == 0)  mask     = 5'($urandom_range(31));
            if ($urandom_range(19) == 0)  modem_in[$urandom_range(2)] = ~modem_in[$urandom_range(2)];
            cyc();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule